// File: doc/BRIEF.md
# Three-State Power Mode Sequencer

This block sequences a processor core between three power modes: full run, idle (core clock gated, interrupts still watched) and sleep (the core domain powered down). Software asks for idle or sleep through single-cycle request strobes, and a wakeup interrupt brings the core back to run. An asynchronous power-fault input is synchronised inside the block and forces the core into sleep.

Every move between modes passes through a timed transitional phase. The length of that phase is a parameter counted in clock cycles. Each kind of move has its own length, and the return from sleep is by far the longest. While a move is in progress the block raises a busy flag and ignores software requests and wakeups. A power fault is the only exception: it aborts any move that is not already heading into sleep and starts a full sleep entry in its place. The outputs are a coarse power-level code, the busy flag, a clock-enable for the core and a power-enable for the core domain. All of them are registered.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in run: `pwr_level` = 2'b10, `busy` = 0, `core_clk_en` = 1, `dom_pwr_en` = 1.
- R2: A `req_idle` pulse in run raises `busy` and drops `core_clk_en` on the next edge. Exactly T_IDLE_ENTRY cycles later `busy` falls and `pwr_level` becomes 2'b01 (idle). `dom_pwr_en` stays 1 throughout.
- R3: A `wake_irq` in idle raises `busy` and `core_clk_en` on the next edge. T_IDLE_EXIT cycles later `busy` falls and `pwr_level` returns to 2'b10.
- R4: A `req_sleep` in run or idle raises `busy` with `core_clk_en` low. T_SLEEP_ENTRY cycles later `pwr_level` becomes 2'b00 (sleep) and `dom_pwr_en` falls. `dom_pwr_en` is 0 only in stable sleep.
- R5: A `wake_irq` in sleep starts the return to run, with `core_clk_en` and `dom_pwr_en` both high during that return. T_SLEEP_EXIT cycles later the level is run. A `req_idle` in sleep has no effect, so sleep never leads to idle.
- R6: `req_idle`, `req_sleep` and `wake_irq` are ignored while `busy` is high.
- R7: A `pwr_fault_in` rise is seen after SYNC_STAGES cycles of synchronisation. In run or idle it then starts a sleep entry of T_SLEEP_ENTRY cycles.
- R8: A synchronised fault during idle entry, idle exit or sleep exit aborts that move and starts a full T_SLEEP_ENTRY sleep entry. `pwr_level` keeps its last stable code until sleep is reached.
- R9: A fault during a sleep entry does not change when sleep is reached.
- R10: While the synchronised fault is high, `wake_irq` in sleep is ignored.
- R11: When several inputs are asserted in the same cycle, the fault wins. After the fault, `req_sleep` beats `req_idle` in run, and `wake_irq` beats `req_sleep` in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_idle | input | 1 | Software request to enter idle (pulse) |
| req_sleep | input | 1 | Software request to enter sleep (pulse) |
| wake_irq | input | 1 | Wakeup interrupt |
| pwr_fault_in | input | 1 | Asynchronous power-fault indication |
| pwr_level | output | 2 | Last stable mode: 10 run, 01 idle, 00 sleep |
| busy | output | 1 | High while a transition is in progress |
| core_clk_en | output | 1 | Core clock enable |
| dom_pwr_en | output | 1 | Core domain power enable |

## Verification
The assertions assume the following about the inputs. Every latency parameter is at least one cycle. `req_idle`, `req_sleep` and `wake_irq` are synchronous to `clk`. `pwr_fault_in` may change at any time, because only its synchronised copy reaches the state machine. The stimulus drives every input on the falling edge. It holds the fault level for many cycles and releases it only after sleep is reached. It waits longer than the synchroniser depth before it sends a wakeup, so every decision the checks rely on falls on a known edge.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN          = 3'd0,
    ST_IDLE         = 3'd1,
    ST_SLEEP        = 3'd2,
    ST_TO_IDLE      = 3'd3,
    ST_IDLE_TO_RUN  = 3'd4,
    ST_TO_SLEEP     = 3'd5,
    ST_SLEEP_TO_RUN = 3'd6
  } seq_state_t;

  localparam logic [1:0] LVL_RUN   = 2'b10;
  localparam logic [1:0] LVL_IDLE  = 2'b01;
  localparam logic [1:0] LVL_SLEEP = 2'b00;

endpackage

// File: rtl/pwr_fault_sync.sv
module pwr_fault_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-2:0], async_in};
  end

  assign sync_out = sh_q[STAGES-1];
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q == '0) |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/pwr_seq_outputs.sv
module pwr_seq_outputs
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t st_n,
  output logic [1:0] pwr_level,
  output logic       busy,
  output logic       core_clk_en,
  output logic       dom_pwr_en
);
  logic is_stable;
  assign is_stable = (st_n == ST_RUN) || (st_n == ST_IDLE) || (st_n == ST_SLEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_level   <= LVL_RUN;
      busy        <= 1'b0;
      core_clk_en <= 1'b1;
      dom_pwr_en  <= 1'b1;
    end else begin
      busy        <= !is_stable;
      core_clk_en <= (st_n == ST_RUN) || (st_n == ST_IDLE_TO_RUN) ||
                     (st_n == ST_SLEEP_TO_RUN);
      dom_pwr_en  <= (st_n != ST_SLEEP);
      if (st_n == ST_RUN)        pwr_level <= LVL_RUN;
      else if (st_n == ST_IDLE)  pwr_level <= LVL_IDLE;
      else if (st_n == ST_SLEEP) pwr_level <= LVL_SLEEP;
    end
  end

  AST_PWR_OFF_ONLY_SLEEP: assert property (@(posedge clk) disable iff (rst)
    !dom_pwr_en |-> (pwr_level == LVL_SLEEP && !busy)); // R4
  AST_CLK_OFF_WHEN_LOW: assert property (@(posedge clk) disable iff (rst)
    (!busy && pwr_level != LVL_RUN) |-> !core_clk_en); // R2
  AST_RUN_CLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!busy && pwr_level == LVL_RUN) |-> (core_clk_en && dom_pwr_en)); // R3
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int T_IDLE_ENTRY  = 100,
  parameter int T_IDLE_EXIT   = 100,
  parameter int T_SLEEP_ENTRY = 900,
  parameter int T_SLEEP_EXIT  = 1600000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_idle,
  input  logic       req_sleep,
  input  logic       wake_irq,
  input  logic       pwr_fault_in,
  output logic [1:0] pwr_level,
  output logic       busy,
  output logic       core_clk_en,
  output logic       dom_pwr_en
);
  localparam int MAX_A = (T_IDLE_ENTRY > T_IDLE_EXIT) ? T_IDLE_ENTRY : T_IDLE_EXIT;
  localparam int MAX_B = (T_SLEEP_ENTRY > T_SLEEP_EXIT) ? T_SLEEP_ENTRY : T_SLEEP_EXIT;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_T + 1);
  localparam logic [CW-1:0] LD_IENT = CW'(T_IDLE_ENTRY - 1);
  localparam logic [CW-1:0] LD_IEX  = CW'(T_IDLE_EXIT - 1);
  localparam logic [CW-1:0] LD_SENT = CW'(T_SLEEP_ENTRY - 1);
  localparam logic [CW-1:0] LD_SEX  = CW'(T_SLEEP_EXIT - 1);

  seq_state_t    st_q, st_n;
  logic          flt_s, tmr_ld, tmr_done;
  logic [CW-1:0] tmr_val;

  pwr_fault_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pwr_fault_in), .sync_out(flt_s));

  pwr_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_ld), .load_val(tmr_val), .done(tmr_done));

  always_comb begin
    st_n    = st_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (st_q)
      ST_RUN: begin
        if (flt_s || req_sleep) begin
          st_n = ST_TO_SLEEP; tmr_ld = 1'b1; tmr_val = LD_SENT;
        end else if (req_idle) begin
          st_n = ST_TO_IDLE;  tmr_ld = 1'b1; tmr_val = LD_IENT;
        end
      end
      ST_IDLE: begin
        if (flt_s) begin
          st_n = ST_TO_SLEEP; tmr_ld = 1'b1; tmr_val = LD_SENT;
        end else if (wake_irq) begin
          st_n = ST_IDLE_TO_RUN; tmr_ld = 1'b1; tmr_val = LD_IEX;
        end else if (req_sleep) begin
          st_n = ST_TO_SLEEP; tmr_ld = 1'b1; tmr_val = LD_SENT;
        end
      end
      ST_SLEEP: begin
        if (!flt_s && wake_irq) begin
          st_n = ST_SLEEP_TO_RUN; tmr_ld = 1'b1; tmr_val = LD_SEX;
        end
      end
      ST_TO_IDLE: begin
        if (flt_s) begin
          st_n = ST_TO_SLEEP; tmr_ld = 1'b1; tmr_val = LD_SENT;
        end else if (tmr_done) st_n = ST_IDLE;
      end
      ST_IDLE_TO_RUN, ST_SLEEP_TO_RUN: begin
        if (flt_s) begin
          st_n = ST_TO_SLEEP; tmr_ld = 1'b1; tmr_val = LD_SENT;
        end else if (tmr_done) st_n = ST_RUN;
      end
      ST_TO_SLEEP: begin
        if (tmr_done) st_n = ST_SLEEP;
      end
      default: st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_RUN;
    else     st_q <= st_n;
  end

  pwr_seq_outputs u_out (
    .clk(clk), .rst(rst), .st_n(st_n), .pwr_level(pwr_level), .busy(busy),
    .core_clk_en(core_clk_en), .dom_pwr_en(dom_pwr_en));

  AST_SLEEP_NEVER_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SLEEP) |=> (st_q == ST_SLEEP || st_q == ST_SLEEP_TO_RUN)); // R5
  AST_IDLE_ENTRY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TO_IDLE && !flt_s) |=> (st_q == ST_TO_IDLE || st_q == ST_IDLE)); // R6
  AST_FAULT_ABORTS: assert property (@(posedge clk) disable iff (rst)
    (flt_s && st_q != ST_SLEEP) |=> (st_q == ST_TO_SLEEP || st_q == ST_SLEEP)); // R8
  AST_SLEEP_ENTRY_KEPT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TO_SLEEP) |=> (st_q == ST_TO_SLEEP || st_q == ST_SLEEP)); // R9
  AST_FAULT_BLOCKS_WAKE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SLEEP && flt_s) |=> (st_q == ST_SLEEP)); // R10
endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TIE = 6, TIX = 5, TSE = 9, TSX = 24, SYN = 2;
  localparam logic [1:0] L_RUN = 2'b10, L_IDLE = 2'b01, L_SLP = 2'b00;

  logic clk = 1'b0, rst = 1'b1;
  logic req_idle = 1'b0, req_sleep = 1'b0, wake_irq = 1'b0, pwr_fault_in = 1'b0;
  logic [1:0] pwr_level;
  logic busy, core_clk_en, dom_pwr_en;

  int cyc = 0, n_run = 0, n_fail = 0;
  bit mon_en = 1'b0, finished = 1'b0;

  typedef struct { int at; logic [4:0] val; string tag; } exp_t;
  exp_t sb_q[$];
  logic [4:0] last_obs;

  pwr_mode_seq #(.T_IDLE_ENTRY(TIE), .T_IDLE_EXIT(TIX), .T_SLEEP_ENTRY(TSE),
                 .T_SLEEP_EXIT(TSX), .SYNC_STAGES(SYN)) i_pwr_mode_seq (
    .clk(clk), .rst(rst), .req_idle(req_idle), .req_sleep(req_sleep),
    .wake_irq(wake_irq), .pwr_fault_in(pwr_fault_in), .pwr_level(pwr_level),
    .busy(busy), .core_clk_en(core_clk_en), .dom_pwr_en(dom_pwr_en));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: every output change pops one expected item
  always @(negedge clk) begin
    if (mon_en) begin
      logic [4:0] cur;
      cur = {pwr_level, busy, core_clk_en, dom_pwr_en};
      if (cur !== last_obs) begin
        n_run++;
        if (sb_q.size() == 0) begin
          n_fail++;
          $display("FAIL R6 unexpected change: got %b exp %b at cycle %0d", cur, last_obs, cyc);
        end else begin
          exp_t x;
          x = sb_q.pop_front();
          if (x.at != cyc || x.val !== cur) begin
            n_fail++;
            $display("FAIL %s: got %b at cycle %0d, exp %b at cycle %0d",
                     x.tag, cur, cyc, x.val, x.at);
          end
        end
        last_obs = cur;
      end
    end
  end

  task automatic exp_ev(input int at, input logic [1:0] lv, input logic b,
                        input logic ce, input logic pe, input string tag);
    exp_t x;
    x.at = at; x.val = {lv, b, ce, pe}; x.tag = tag;
    sb_q.push_back(x);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic pi, input logic ps, input logic pw);
    req_idle = pi; req_sleep = ps; wake_irq = pw;
    @(negedge clk);
    req_idle = 1'b0; req_sleep = 1'b0; wake_irq = 1'b0;
  endtask

  task automatic go_idle();  // R2
    int e; e = cyc + 1;
    exp_ev(e, L_RUN, 1, 0, 1, "R2 idle entry start");
    exp_ev(e + TIE, L_IDLE, 0, 0, 1, "R2 idle reached");
    pulse(1, 0, 0);
    settle(TIE + 2);
  endtask

  task automatic wake_from_sleep();  // R5
    int e; e = cyc + 1;
    exp_ev(e, L_SLP, 1, 1, 1, "R5 sleep exit start");
    exp_ev(e + TSX, L_RUN, 0, 1, 1, "R5 run reached");
    pulse(0, 0, 1);
    settle(TSX + 2);
  endtask

  task automatic fault_release();
    pwr_fault_in = 1'b0;
    settle(SYN + 2);
  endtask

  initial begin
    int e, ef;
    settle(4);
    rst = 1'b0;
    // R1 reset state
    n_run++;
    if ({pwr_level, busy, core_clk_en, dom_pwr_en} !== {L_RUN, 3'b011}) begin
      n_fail++;
      $display("FAIL R1 reset: got %b exp %b", {pwr_level, busy, core_clk_en, dom_pwr_en},
               {L_RUN, 3'b011});
    end
    last_obs = {L_RUN, 3'b011};
    mon_en = 1'b1;
    settle(2);

    // R2 with R6: requests during idle entry are ignored
    e = cyc + 1;
    exp_ev(e, L_RUN, 1, 0, 1, "R2 idle entry start");
    exp_ev(e + TIE, L_IDLE, 0, 0, 1, "R2/R6 idle reached on time");
    pulse(1, 0, 0);
    pulse(0, 1, 1);
    settle(TIE + 2);

    // R3 idle exit
    e = cyc + 1;
    exp_ev(e, L_IDLE, 1, 1, 1, "R3 idle exit start");
    exp_ev(e + TIX, L_RUN, 0, 1, 1, "R3 run reached");
    pulse(0, 0, 1);
    settle(TIX + 2);

    // R11 run: sleep beats idle; R4 sleep from run
    e = cyc + 1;
    exp_ev(e, L_RUN, 1, 0, 1, "R11 sleep wins in run");
    exp_ev(e + TSE, L_SLP, 0, 0, 0, "R4 sleep reached from run");
    pulse(1, 1, 0);
    settle(TSE + 2);

    // R5 idle request in sleep ignored, then wake
    pulse(1, 0, 0);
    settle(3);
    wake_from_sleep();

    // R4 sleep from idle
    go_idle();
    e = cyc + 1;
    exp_ev(e, L_IDLE, 1, 0, 1, "R4 sleep entry from idle");
    exp_ev(e + TSE, L_SLP, 0, 0, 0, "R4 sleep reached from idle");
    pulse(0, 1, 0);
    settle(TSE + 2);
    wake_from_sleep();

    // R11 idle: wake beats sleep request
    go_idle();
    e = cyc + 1;
    exp_ev(e, L_IDLE, 1, 1, 1, "R11 wake wins in idle");
    exp_ev(e + TIX, L_RUN, 0, 1, 1, "R11 run reached");
    pulse(0, 1, 1);
    settle(TIX + 2);

    // R7 fault in run, R10 wake blocked while fault high
    e = cyc + 1;
    exp_ev(e + SYN, L_RUN, 1, 0, 1, "R7 fault in run");
    exp_ev(e + SYN + TSE, L_SLP, 0, 0, 0, "R7 sleep after fault");
    pwr_fault_in = 1'b1;
    settle(SYN + TSE + 3);
    pulse(0, 0, 1);
    settle(3);
    fault_release();
    wake_from_sleep();

    // R7 fault in idle
    go_idle();
    e = cyc + 1;
    exp_ev(e + SYN, L_IDLE, 1, 0, 1, "R7 fault in idle");
    exp_ev(e + SYN + TSE, L_SLP, 0, 0, 0, "R7 sleep after idle fault");
    pwr_fault_in = 1'b1;
    settle(SYN + TSE + 3);
    fault_release();
    wake_from_sleep();

    // R8 fault aborts idle entry
    e = cyc + 1;
    exp_ev(e, L_RUN, 1, 0, 1, "R8 idle entry start");
    pulse(1, 0, 0);
    ef = cyc + 1;
    exp_ev(ef + SYN + TSE, L_SLP, 0, 0, 0, "R8 abort idle entry to sleep");
    pwr_fault_in = 1'b1;
    settle(SYN + TSE + 3);
    fault_release();
    wake_from_sleep();

    // R8 fault aborts idle exit
    go_idle();
    e = cyc + 1;
    exp_ev(e, L_IDLE, 1, 1, 1, "R8 idle exit start");
    pulse(0, 0, 1);
    ef = cyc + 1;
    exp_ev(ef + SYN, L_IDLE, 1, 0, 1, "R8 abort idle exit");
    exp_ev(ef + SYN + TSE, L_SLP, 0, 0, 0, "R8 sleep after idle exit abort");
    pwr_fault_in = 1'b1;
    settle(SYN + TSE + 3);
    fault_release();

    // R8 fault aborts sleep exit
    e = cyc + 1;
    exp_ev(e, L_SLP, 1, 1, 1, "R8 sleep exit start");
    pulse(0, 0, 1);
    ef = cyc + 1;
    exp_ev(ef + SYN, L_SLP, 1, 0, 1, "R8 abort sleep exit");
    exp_ev(ef + SYN + TSE, L_SLP, 0, 0, 0, "R8 sleep after sleep exit abort");
    pwr_fault_in = 1'b1;
    settle(SYN + TSE + 3);
    fault_release();
    wake_from_sleep();

    // R9 fault during sleep entry keeps its timing; R10 wake blocked
    e = cyc + 1;
    exp_ev(e, L_RUN, 1, 0, 1, "R9 sleep entry start");
    exp_ev(e + TSE, L_SLP, 0, 0, 0, "R9 sleep time unchanged by fault");
    pulse(0, 1, 0);
    pwr_fault_in = 1'b1;
    settle(TSE + 2);
    pulse(0, 0, 1);
    settle(3);
    fault_release();
    wake_from_sleep();

    settle(5);
    n_run++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R6 missing changes: got %0d pending exp 0", sb_q.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule